// File: doc/BRIEF.md
# Retired Instruction Trace Classifier

This block watches a processor's instruction-retirement trace port and builds running statistics from it. On every cycle where the retire strobe is high, it counts the instruction against the privilege level it ran at. It also counts taken jumps and register-file writes. When the retired instruction also raised an exception, the 6-bit cause code is sorted into one of seven categories, and that category's counter advances. The program counter and the cause of that exception are kept as the most recent exception record.

The cause code space is sparse, and most values are reserved. A reserved cause goes to a separate anomaly counter, as does the unused privilege encoding. No category or privilege counter moves for them. Every counter saturates at its maximum. Software or a debug probe reads the flat counter buses directly.

Top module: `trace_retire_classifier`

## Requirements
- R1: After reset is asserted, every counter output reads 0, and the last-exception PC and code outputs also read 0.
- R2: While `retire_valid_i` is 0, no output changes, whatever the other trace inputs are.
- R3: The cause code and the exception-taken input have an effect only when both `retire_valid_i` and `exc_taken_i` are 1. A retired instruction without an exception leaves every category counter and the last-exception record untouched.
- R4: Each retired instruction increments one privilege slot of `priv_cnt_o`, selected by `priv_i`:
  - 2'b00 selects slot 0 (user).
  - 2'b01 selects slot 1 (supervisor).
  - 2'b11 selects slot 2 (machine).
  - 2'b10 increments `anom_cnt_o` instead of any privilege slot.
- R5: A qualified exception increments exactly one slot of `cat_cnt_o`, chosen by cause code:
  - Slot 0, misaligned: codes 0, 4 and 6.
  - Slot 1, access fault: codes 1, 5 and 7.
  - Slot 2, page fault: codes 12, 13 and 15.
  - Slot 3, environment call: codes 8, 9 and 11.
  - Slot 4, interrupt: codes 32 and 43.
  - Slot 5, debug break: code 48.
  - Slot 6, other: codes 2, 3 and 24.
- R6: A qualified exception with any cause code not listed in R5 increments `anom_cnt_o` and no category slot. `anom_cnt_o` rises by at most 1 per instruction, even when both the cause and the privilege are anomalous.
- R7: A retired instruction with `jump_taken_i` set increments `jump_cnt_o`, and one with `reg_write_i` set increments `wr_cnt_o`.
- R8: Every counter saturates at 2**CNT_W-1 and stays there when further increments arrive.
- R9: On a qualified exception, `last_pc_o` and `last_code_o` load `pc_i` and `exc_code_i`. This happens for reserved codes as well. Otherwise both hold their value.
- R10: Every output reflects a retired instruction exactly one clock edge after that instruction is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_valid_i | input | 1 | A retired instruction is present this cycle |
| exc_taken_i | input | 1 | The retired instruction took an exception |
| exc_code_i | input | 6 | Exception cause code |
| jump_taken_i | input | 1 | The retired instruction was a taken jump or branch |
| reg_write_i | input | 1 | The retired instruction wrote the register file |
| priv_i | input | 2 | Privilege level of the retired instruction |
| pc_i | input | PC_W | Program counter of the retired instruction |
| priv_cnt_o | output | 3*CNT_W | Retire counts per privilege; slot k at [k*CNT_W +: CNT_W] |
| cat_cnt_o | output | 7*CNT_W | Exception counts per category; slot k at [k*CNT_W +: CNT_W] |
| jump_cnt_o | output | CNT_W | Taken-jump count |
| wr_cnt_o | output | CNT_W | Register-write count |
| anom_cnt_o | output | CNT_W | Reserved cause / unused privilege count |
| last_pc_o | output | PC_W | PC of the most recent qualified exception |
| last_code_o | output | 6 | Cause code of the most recent qualified exception |

## Verification
Every result here is a single register stage away from the sampled inputs. A counter increment or a last-exception load therefore becomes visible right after the rising edge that samples the retire strobe. The bench drives each cycle's inputs on the falling edge, advances its own model as of the coming rising edge, and compares every output on the next falling edge. Each comparison therefore lands exactly one edge after its stimulus. Idle and exception-free cycles are checked the same way, so an output that moves when it must not is caught in the same cycle.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int NUM_CAT  = 7;
  localparam int NUM_PRIV = 3;
  localparam int CODE_W   = 6;

  typedef enum logic [2:0] {
    CAT_MISALIGN = 3'd0,
    CAT_ACCESS   = 3'd1,
    CAT_PAGE     = 3'd2,
    CAT_ECALL    = 3'd3,
    CAT_INTR     = 3'd4,
    CAT_DBG      = 3'd5,
    CAT_OTHER    = 3'd6
  } exc_cat_e;
endpackage

// File: rtl/trc_cause_decode.sv
module trc_cause_decode
  import trc_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output exc_cat_e          cat_o,
  output logic              rsvd_o
);
  always_comb begin
    rsvd_o = 1'b0;
    unique case (code_i)
      6'd0, 6'd4, 6'd6:    cat_o = CAT_MISALIGN;
      6'd1, 6'd5, 6'd7:    cat_o = CAT_ACCESS;
      6'd12, 6'd13, 6'd15: cat_o = CAT_PAGE;
      6'd8, 6'd9, 6'd11:   cat_o = CAT_ECALL;
      6'd32, 6'd43:        cat_o = CAT_INTR;
      6'd48:               cat_o = CAT_DBG;
      6'd2, 6'd3, 6'd24:   cat_o = CAT_OTHER;
      default: begin
        cat_o  = CAT_OTHER;
        rsvd_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/trc_sat_counter.sv
module trc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= '0;
    else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
  end

  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o == MAX |=> cnt_o == MAX); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_o)); // R2
endmodule

// File: rtl/trc_last_exc.sv
module trc_last_exc
  import trc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [CODE_W-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o   <= '0;
      code_o <= '0;
    end else if (cap_i) begin
      pc_o   <= pc_i;
      code_o <= code_i;
    end
  end

  AST_LAST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(pc_o) && $stable(code_o)); // R9
  AST_LAST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> pc_o == $past(pc_i) && code_o == $past(code_i)); // R9
endmodule

// File: rtl/trace_retire_classifier.sv
module trace_retire_classifier
  import trc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PC_W  = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      retire_valid_i,
  input  logic                      exc_taken_i,
  input  logic [CODE_W-1:0]         exc_code_i,
  input  logic                      jump_taken_i,
  input  logic                      reg_write_i,
  input  logic [1:0]                priv_i,
  input  logic [PC_W-1:0]           pc_i,
  output logic [NUM_PRIV*CNT_W-1:0] priv_cnt_o,
  output logic [NUM_CAT*CNT_W-1:0]  cat_cnt_o,
  output logic [CNT_W-1:0]          jump_cnt_o,
  output logic [CNT_W-1:0]          wr_cnt_o,
  output logic [CNT_W-1:0]          anom_cnt_o,
  output logic [PC_W-1:0]           last_pc_o,
  output logic [CODE_W-1:0]         last_code_o
);
  exc_cat_e            cat;
  logic                rsvd;
  logic                exc_qual;
  logic                priv_bad;
  logic                anom_inc;
  logic [NUM_PRIV-1:0] priv_inc;
  logic [NUM_CAT-1:0]  cat_inc;

  trc_cause_decode i_decode (
    .code_i (exc_code_i),
    .cat_o  (cat),
    .rsvd_o (rsvd)
  );

  // exception fields qualified by both strobes
  assign exc_qual = retire_valid_i & exc_taken_i;
  assign priv_bad = (priv_i == 2'b10);
  assign anom_inc = retire_valid_i & (priv_bad | (exc_qual & rsvd));

  always_comb begin
    priv_inc = '0;
    if (retire_valid_i) begin
      unique case (priv_i)
        2'b00:   priv_inc[0] = 1'b1;
        2'b01:   priv_inc[1] = 1'b1;
        2'b11:   priv_inc[2] = 1'b1;
        default: priv_inc    = '0;
      endcase
    end
  end

  for (genvar p = 0; p < NUM_PRIV; p++) begin : g_priv
    trc_sat_counter #(.W(CNT_W)) i_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (priv_inc[p]),
      .cnt_o  (priv_cnt_o[p*CNT_W +: CNT_W])
    );
  end

  for (genvar c = 0; c < NUM_CAT; c++) begin : g_cat
    assign cat_inc[c] = exc_qual & ~rsvd & (int'(cat) == c);
    trc_sat_counter #(.W(CNT_W)) i_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (cat_inc[c]),
      .cnt_o  (cat_cnt_o[c*CNT_W +: CNT_W])
    );
  end

  trc_sat_counter #(.W(CNT_W)) i_jump_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (retire_valid_i & jump_taken_i),
    .cnt_o  (jump_cnt_o)
  );

  trc_sat_counter #(.W(CNT_W)) i_wr_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (retire_valid_i & reg_write_i),
    .cnt_o  (wr_cnt_o)
  );

  trc_sat_counter #(.W(CNT_W)) i_anom_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (anom_inc),
    .cnt_o  (anom_cnt_o)
  );

  trc_last_exc #(.PC_W(PC_W)) i_last (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (exc_qual),
    .pc_i   (pc_i),
    .code_i (exc_code_i),
    .pc_o   (last_pc_o),
    .code_o (last_code_o)
  );

  AST_PRIV_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(priv_inc)); // R4
  AST_CAT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cat_inc)); // R5
  AST_NO_EXC_NO_CAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_qual |=> $stable(cat_cnt_o) && $stable(last_code_o)); // R3
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_valid_i |=> $stable(priv_cnt_o) && $stable(anom_cnt_o)
                        && $stable(jump_cnt_o) && $stable(wr_cnt_o)); // R2
endmodule

// File: tb/test_trace_retire_classifier.sv
module test_trace_retire_classifier;
  localparam int CNT_W = 5;
  localparam int PC_W  = 32;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, exc = 1'b0, jmp = 1'b0, wr = 1'b0;
  logic [5:0] code = '0;
  logic [1:0] priv = '0;
  logic [PC_W-1:0] pc = '0;
  logic [3*CNT_W-1:0] priv_cnt;
  logic [7*CNT_W-1:0] cat_cnt;
  logic [CNT_W-1:0] jump_cnt, wr_cnt, anom_cnt;
  logic [PC_W-1:0] last_pc;
  logic [5:0] last_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_priv[3];
  int m_cat[7];
  int m_jump, m_wr, m_anom;
  logic [PC_W-1:0] m_pc;
  logic [5:0] m_code;

  always #2.5 clk = ~clk;

  trace_retire_classifier #(.CNT_W(CNT_W), .PC_W(PC_W)) i_trace_retire_classifier (
    .clk_i(clk), .rst_ni(rst_n), .retire_valid_i(vld), .exc_taken_i(exc),
    .exc_code_i(code), .jump_taken_i(jmp), .reg_write_i(wr), .priv_i(priv),
    .pc_i(pc), .priv_cnt_o(priv_cnt), .cat_cnt_o(cat_cnt), .jump_cnt_o(jump_cnt),
    .wr_cnt_o(wr_cnt), .anom_cnt_o(anom_cnt), .last_pc_o(last_pc), .last_code_o(last_code)
  );

  // category of a cause code per R5; -1 means reserved (R6)
  function automatic int cat_of(input int c);
    case (c)
      0, 4, 6:    return 0;
      1, 5, 7:    return 1;
      12, 13, 15: return 2;
      8, 9, 11:   return 3;
      32, 43:     return 4;
      48:         return 5;
      2, 3, 24:   return 6;
      default:    return -1;
    endcase
  endfunction

  function automatic int sat(input int v);
    return (v >= MAXV) ? MAXV : v + 1;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string phase);
    for (int k = 0; k < 3; k++)
      chk({phase, " R4"}, $sformatf("priv slot %0d", k), priv_cnt[k*CNT_W +: CNT_W], m_priv[k]);
    for (int k = 0; k < 7; k++)
      chk({phase, " R5"}, $sformatf("cat slot %0d", k), cat_cnt[k*CNT_W +: CNT_W], m_cat[k]);
    chk({phase, " R6"}, "anomaly", anom_cnt, m_anom);
    chk({phase, " R7"}, "jump", jump_cnt, m_jump);
    chk({phase, " R7"}, "regwrite", wr_cnt, m_wr);
    chk({phase, " R9"}, "last pc", last_pc, m_pc);
    chk({phase, " R9"}, "last code", last_code, m_code);
  endtask

  // drive at falling edge, model as of next rising edge, compare at next falling edge (R10)
  task automatic step(input string phase, input bit v, input bit e, input int c, input bit j,
                      input bit w, input int p, input logic [PC_W-1:0] addr);
    vld = v; exc = e; code = 6'(c); jmp = j; wr = w; priv = 2'(p); pc = addr;
    if (v) begin
      if (p == 2) m_anom = sat(m_anom);
      else begin
        if (p == 0) m_priv[0] = sat(m_priv[0]);
        if (p == 1) m_priv[1] = sat(m_priv[1]);
        if (p == 3) m_priv[2] = sat(m_priv[2]);
      end
      if (j) m_jump = sat(m_jump);
      if (w) m_wr = sat(m_wr);
      if (e) begin
        m_pc = addr; m_code = 6'(c);
        if (cat_of(c) < 0) begin
          if (p != 2) m_anom = sat(m_anom);
        end else m_cat[cat_of(c)] = sat(m_cat[cat_of(c)]);
      end
    end
    @(negedge clk);
    compare_all(phase);
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) m_priv[k] = 0;
    for (int k = 0; k < 7; k++) m_cat[k] = 0;
    m_jump = 0; m_wr = 0; m_anom = 0; m_pc = '0; m_code = '0;
    repeat (3) @(negedge clk);
    compare_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // every cause code once, user privilege, each in its own cycle
    for (int c = 0; c < 64; c++)
      step("R5/R6 sweep", 1, 1, c, 0, 0, 0, 32'h1000 + 32'(c * 4));
    // inputs toggling with no retire strobe: nothing moves
    for (int c = 0; c < 10; c++)
      step("R2 idle", 0, 1, c, 1, 1, c % 4, 32'hDEAD_0000 + 32'(c));
    // retire without exception: code ignored, last record held
    for (int c = 0; c < 8; c++)
      step("R3 no-exc", 1, 0, c, 0, 1, 3, 32'hBEEF_0000 + 32'(c));
    // unused privilege, with and without a reserved cause
    step("R4 priv10", 1, 0, 0, 0, 0, 2, 32'h2000);
    step("R6 priv10+rsvd", 1, 1, 63, 0, 0, 2, 32'h2004);
    step("R4 super", 1, 0, 0, 1, 0, 1, 32'h2008);
    // saturation burst on jump and machine counters
    for (int c = 0; c < 40; c++)
      step("R8 sat", 1, 0, 0, 1, 1, 3, 32'h3000);
    // mixed traffic
    for (int n = 0; n < 1500; n++) begin
      int cc;
      cc = ($urandom % 2 == 0) ? int'($urandom % 64) : int'($urandom % 49);
      step("R10 mix", ($urandom % 10) < 7, ($urandom % 10) < 3, cc,
           $urandom % 2 == 1, $urandom % 2 == 1, int'($urandom % 4), 32'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule